// File: doc/BRIEF.md
# Programmable Prescaler and Rate Selector

This block divides a free-running oscillator clock down to a once-per-second update tick. It also produces a programmable sub-second rate that drives two outputs. The oscillator-select field tells the block how fast the incoming clock is. The block then sets the number of binary stages, so that the tick period is always one second. Two oscillator-select codes hold the whole chain cleared. Releasing that hold starts counting from zero, and the first tick then arrives half a second later.

A four-bit rate field picks one tap of the chain. That tap feeds two outputs, each with its own enable:
- a one-cycle periodic event pulse, issued each time the tap rises;
- a square-wave pin with a 50% duty cycle.

The frequency table is the same for both fast oscillators. For the slow oscillator, the two highest rate codes are replaced by slower rates. The block runs in the oscillator clock domain. Its outputs are meant for a timekeeping unit and an interrupt-flag unit, which sit elsewhere.

In the default configuration, the three chain lengths are 22, 20 and 15 stages, and the rate reference exponent is 16. A rate code n on a fast oscillator gives 65536 >> n Hz.

Top module: `rsel_prescaler`

## Requirements
- R1: While `rst_n` is low, the chain is cleared and `tick_1hz`, `per_pulse` and `sqw_out` are all low.
- R2: The chain length N depends on `osc_sel`: code 000 gives STG_HI (22) stages, code 001 gives STG_MID (20) stages, and codes 010, 011, 100 and 101 give STG_LOW (15) stages. After the first tick, `tick_1hz` repeats every 2^N clock cycles.
- R3: Counting from the first clock edge after the hold or reset is released, `tick_1hz` is high for exactly one cycle, after 2^(N-1) edges (half a second).
- R4: `osc_sel` codes 110 and 111 hold the chain cleared. While either code is applied, all three outputs stay low, whatever the other inputs are.
- R5: On codes 000 and 001, rate code n (1 to 15) selects a tap of period 2^(N-RATE_TOP+n) cycles. With the defaults this is 65536 >> n Hz.
- R6: On the slow codes, rate code 0001 gives 256 Hz and rate code 0010 gives 128 Hz. These act as rate codes RATE_TOP/2 and RATE_TOP/2+1. Codes 3 to 15 follow R5.
- R7: Rate code 0000 keeps `per_pulse` and `sqw_out` low.
- R8: When `pie_en` is high, `per_pulse` is high for one cycle each time the tap rises. The k-th pulse (k from 0) comes after 2^(p-1) + k*2^p edges, where 2^p is the tap period. When `pie_en` is low, `per_pulse` stays low.
- R9: When `sqw_en` is high, `sqw_out` toggles every 2^(p-1) edges, and its first rising edge comes after 2^(p-1) edges. When `sqw_en` is low, `sqw_out` stays low.
- R10: The tick and the periodic pulse are independent. When their schedules meet in the same cycle, both outputs are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock that the chain counts |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_sel | input | 3 | Oscillator frequency code; 11x holds the chain cleared |
| rate_sel | input | 4 | Tap select for the periodic pulse and the square wave |
| pie_en | input | 1 | Enables the periodic event pulse |
| sqw_en | input | 1 | Enables the square-wave pin |
| tick_1hz | output | 1 | One-cycle update tick, once per second |
| per_pulse | output | 1 | One-cycle pulse on each rise of the selected tap |
| sqw_out | output | 1 | 50% square wave at the selected rate |

## Verification
The once-per-second tick and the periodic pulse can fire in the same cycle. This happens when the selected tap period equals the full chain period. Then the pulse at 2^(p-1) falls exactly on the half-second tick, and again every full period after it. The bench sets up that case with the fastest oscillator and a rate code whose tap is the top chain stage. It queues the expected cycle numbers for both events independently, and the monitor requires each one to appear in its own queue at that exact cycle. Neither event may be missing or arrive late, so an implementation that gives one event priority over the other is caught.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

  // Number of divider stages for a given oscillator code.
  function automatic int unsigned chain_len(input logic [2:0] osc,
                                            input int unsigned n_hi,
                                            input int unsigned n_mid,
                                            input int unsigned n_lo);
    case (osc)
      3'b000:  return n_hi;
      3'b001:  return n_mid;
      default: return n_lo;
    endcase
  endfunction

  // Codes 11x hold the chain in its cleared state.
  function automatic logic osc_holds(input logic [2:0] osc);
    return osc[2:1] == 2'b11;
  endfunction

  // Log2 of the tap period in oscillator cycles.
  function automatic int unsigned tap_exp(input logic [2:0] osc,
                                          input logic [3:0] rate,
                                          input int unsigned n,
                                          input int unsigned top);
    int unsigned eff;
    eff = 32'(rate);
    if (osc != 3'b000 && osc != 3'b001) begin
      if (rate == 4'd1)      eff = top / 2;
      else if (rate == 4'd2) eff = top / 2 + 1;
    end
    return n + eff - top;
  endfunction

endpackage

// File: rtl/rsel_chain.sv
module rsel_chain #(
  parameter int unsigned STG_HI  = 22,
  parameter int unsigned STG_MID = 20,
  parameter int unsigned STG_LOW = 15,
  parameter int unsigned CW      = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    osc_sel,
  output logic [CW-1:0] count,
  output logic          hold,
  output logic          tick
);
  import rsel_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  int unsigned   len;
  logic [CW-1:0] len_mask;
  logic [CW-1:0] len_half;

  assign hold = osc_holds(osc_sel);

  always_comb begin
    len      = chain_len(osc_sel, STG_HI, STG_MID, STG_LOW);
    len_mask = (ONE << len) - ONE;
    len_half = ONE << (len - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold) count <= '0;
    else                count <= count + ONE;
  end

  assign tick = !hold && ((count & len_mask) == len_half);

  // R4: a held chain is cleared on the following edge
  a_r4_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0));

  // R3: tick lasts a single cycle while the oscillator code is steady
  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || !$stable(osc_sel)));

endmodule

// File: rtl/rsel_tap.sv
module rsel_tap #(
  parameter int unsigned STG_HI   = 22,
  parameter int unsigned STG_MID  = 20,
  parameter int unsigned STG_LOW  = 15,
  parameter int unsigned RATE_TOP = 16,
  parameter int unsigned CW       = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          hold,
  input  logic [2:0]    osc_sel,
  input  logic [3:0]    rate_sel,
  input  logic          pie_en,
  input  logic          sqw_en,
  output logic          per_pulse,
  output logic          sqw_out
);
  import rsel_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  int unsigned   p;
  logic [CW-1:0] tap_mask;
  logic [CW-1:0] tap_half;
  logic          tap_on;
  logic          tap_bit;
  logic          tap_rise;

  always_comb begin
    p        = tap_exp(osc_sel, rate_sel,
                       chain_len(osc_sel, STG_HI, STG_MID, STG_LOW), RATE_TOP);
    tap_mask = (ONE << p) - ONE;
    tap_half = ONE << (p - 1);
    tap_on   = (rate_sel != 4'd0) && !hold;
    tap_bit  = |(count & tap_half);
    tap_rise = (count & tap_mask) == tap_half;
  end

  assign per_pulse = tap_on && pie_en && tap_rise;
  assign sqw_out   = tap_on && sqw_en && tap_bit;

  // R7: rate code zero silences both outputs
  a_r7_rate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |-> (!per_pulse && !sqw_out));

  // R8: a pulse is never followed by another under steady controls
  a_r8_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    per_pulse |=> (!per_pulse || !$stable(rate_sel) || !$stable(osc_sel)));

  // R9: with both outputs enabled and steady controls, a pulse marks a square-wave rise
  a_r9_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (per_pulse && sqw_en && $past(sqw_en) && $stable(rate_sel) && $stable(osc_sel))
      |-> $rose(sqw_out));

endmodule

// File: rtl/rsel_prescaler.sv
module rsel_prescaler #(
  parameter int unsigned STG_HI   = 22,
  parameter int unsigned STG_MID  = 20,
  parameter int unsigned STG_LOW  = 15,
  parameter int unsigned RATE_TOP = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] osc_sel,
  input  logic [3:0] rate_sel,
  input  logic       pie_en,
  input  logic       sqw_en,
  output logic       tick_1hz,
  output logic       per_pulse,
  output logic       sqw_out
);
  localparam int unsigned CW_CHAIN = STG_HI;
  localparam int unsigned CW_TAP   = STG_HI + 15 - RATE_TOP;
  localparam int unsigned CW       = (CW_CHAIN > CW_TAP) ? CW_CHAIN : CW_TAP;

  logic [CW-1:0] chain_cnt;
  logic          chain_hold;

  rsel_chain #(
    .STG_HI(STG_HI), .STG_MID(STG_MID), .STG_LOW(STG_LOW), .CW(CW)
  ) u_chain (
    .clk(clk), .rst_n(rst_n), .osc_sel(osc_sel),
    .count(chain_cnt), .hold(chain_hold), .tick(tick_1hz)
  );

  rsel_tap #(
    .STG_HI(STG_HI), .STG_MID(STG_MID), .STG_LOW(STG_LOW),
    .RATE_TOP(RATE_TOP), .CW(CW)
  ) u_tap (
    .clk(clk), .rst_n(rst_n), .count(chain_cnt), .hold(chain_hold),
    .osc_sel(osc_sel), .rate_sel(rate_sel), .pie_en(pie_en), .sqw_en(sqw_en),
    .per_pulse(per_pulse), .sqw_out(sqw_out)
  );

  // R4: nothing leaves the block while the chain is held
  a_r4_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    chain_hold |=> (chain_hold || (!tick_1hz && !per_pulse && !sqw_out)));

endmodule

// File: tb/rsel_prescaler_tb_top.sv
module rsel_prescaler_tb_top;
  localparam int NH = 12, NM = 10, NL = 9, RT = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] osc = 3'b000;
  logic [3:0] rate = 4'd1;
  logic       pie = 1'b1, sqw = 1'b1;
  wire        tick, pulse, sq;

  rsel_prescaler #(.STG_HI(NH), .STG_MID(NM), .STG_LOW(NL), .RATE_TOP(RT)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_sel(osc), .rate_sel(rate),
    .pie_en(pie), .sqw_en(sqw),
    .tick_1hz(tick), .per_pulse(pulse), .sqw_out(sq)
  );

  always #4 clk = ~clk;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    active = 0, done = 0;
  string tg = "";
  int    q_tick[$], q_pul[$], q_sq[$];
  logic  sq_prev = 1'b0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected values, written from the requirement tables
  function automatic int nlen(logic [2:0] o);
    if (o == 3'b000) return NH;
    if (o == 3'b001) return NM;
    return NL;
  endfunction

  function automatic int pexp(logic [2:0] o, logic [3:0] r);
    int fexp;                       // log2 of the tap rate per "second"
    fexp = RT - int'(r);
    if (o[2:1] != 2'b00 || o[0] == 1'b0 && o[1] == 1'b1) begin
      if (r == 4'd1) fexp = RT / 2;
      if (r == 4'd2) fexp = RT / 2 - 1;
    end
    if (o == 3'b000 || o == 3'b001) fexp = RT - int'(r);
    return nlen(o) - fexp;
  endfunction

  // Monitor: pops the scoreboard as events appear
  always @(negedge clk) begin
    if (active) begin
      if (tick) begin
        if (q_tick.size() == 0) chk({tg, " R3 unexpected tick"}, cyc, -1);
        else chk({tg, " R3 tick cycle"}, cyc, q_tick.pop_front());
      end
      if (pulse) begin
        if (q_pul.size() == 0) chk({tg, " R8 unexpected pulse"}, cyc, -1);
        else chk({tg, " R8 pulse cycle"}, cyc, q_pul.pop_front());
      end
      if (sq !== sq_prev) begin
        if (q_sq.size() == 0) chk({tg, " R9 unexpected edge"}, cyc, -1);
        else chk({tg, " R9 edge cycle"}, cyc, q_sq.pop_front());
      end
      sq_prev = sq;
      cyc++;
    end
  end

  task automatic run(logic [2:0] o, logic [3:0] r, logic pe, logic se, int ncyc, string t);
    int n, p;
    @(posedge clk); #2;
    osc = 3'b110;
    repeat (3) @(posedge clk);
    #2;
    rate = r; pie = pe; sqw = se; tg = t;
    if (o[2:1] != 2'b11) begin
      n = nlen(o);
      for (int c = 1 << (n - 1); c < ncyc; c += 1 << n) q_tick.push_back(c);
      if (r != 4'd0) begin
        p = pexp(o, r);
        if (pe) for (int c = 1 << (p - 1); c < ncyc; c += 1 << p) q_pul.push_back(c);
        if (se) for (int c = 1 << (p - 1); c < ncyc; c += 1 << (p - 1)) q_sq.push_back(c);
      end
    end
    osc = o; cyc = 0; sq_prev = 1'b0; active = 1;
    repeat (ncyc) @(posedge clk);
    #2;
    active = 0;
    chk({t, " R3 missing ticks"}, q_tick.size(), 0);
    chk({t, " R8 missing pulses"}, q_pul.size(), 0);
    chk({t, " R9 missing edges"}, q_sq.size(), 0);
    q_tick.delete(); q_pul.delete(); q_sq.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 tick in reset", int'(tick), 0);
    chk("R1 pulse in reset", int'(pulse), 0);
    chk("R1 sqw in reset", int'(sq), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    run(3'b000, 4'd10, 1, 1, 7000, "R10 R2 coincide");
    run(3'b000, 4'd1,  1, 1, 3000, "R5 fast hi");
    run(3'b001, 4'd4,  1, 0, 1200, "R5 R2 fast mid");
    run(3'b010, 4'd1,  1, 1, 1500, "R6 slow code1");
    run(3'b011, 4'd2,  1, 1, 1500, "R6 slow code2");
    run(3'b100, 4'd3,  1, 1, 600,  "R6 slow code3");
    run(3'b101, 4'd15, 1, 1, 9000, "R6 slow code15");
    run(3'b000, 4'd0,  1, 1, 2500, "R7 rate off");
    run(3'b001, 4'd3,  0, 1, 500,  "R8 pulse disabled");
    run(3'b111, 4'd1,  1, 1, 300,  "R4 hold");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule